// File: doc/BRIEF.md
# Host-Paced Dual Position Sampler

This block sits between two signed position counters and an external byte-wide FIFO device that bridges to a host computer. After reset it reads one command byte from the FIFO's receive side. That byte picks the sampling period, either a short or a long one. The block then runs a tick counter. On every tick it freezes both positions into one record and sends that record to the host as bytes through the FIFO's transmit side. After a fixed number of records it stops and waits for the next command.

The FIFO device has active-low read and write strobes and two active-low status flags: data is waiting on the receive side, and there is room on the transmit side. Both flags reach the block asynchronously, so each one passes through a two-flop synchroniser before any state machine looks at it. The data bus is split into an input, an output and an output enable, so that a pad ring can build the bidirectional pins.

If a tick falls while a record is still being sent, the block skips that tick and raises a sticky overrun flag.

Top module: `sample_link_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, rd_n and wr_n are 1, bus_oe is 0, running is 0 and overrun is 0.
- R2: A read cycle waits for as long as rx_avail_n is high. Once it is low, rd_n is driven low for exactly STROBE_CLKS clocks, and the byte on bus_din is taken at the end of that pulse.
- R3: The command byte 8'h01 starts a run with a TICKS_FAST clock period, and 8'h02 starts a run with a TICKS_SLOW clock period. Any other byte leaves running at 0, produces no write, and is followed by a new read cycle.
- R4: While the FIFO is never full, the first write strobes of consecutive records are spaced by exactly the selected period in clocks.
- R5: A record holds the pos1 and pos2 values present at the tick that started it. Changes to the inputs while the record is being sent do not alter it.
- R6: Each record is REC_BYTES (4) bytes, in this order: pos1[7:0], pos1[15:8], pos2[7:0], pos2[15:8].
- R7: A write cycle waits for as long as tx_room_n is high. wr_n is then low for exactly STROBE_CLKS clocks. bus_oe is 1 for the whole time wr_n is low, and bus_dout does not change during that time. bus_oe is 0 when no write cycle is in progress.
- R8: A run sends exactly NUM_SAMPLES records. running then drops to 0, and no further bytes are written until a new valid command arrives.
- R9: A tick that arrives while a record is in flight sets overrun, produces no extra record, and does not change the record count. overrun stays set until the next valid command, which clears it.
- R10: rd_n and wr_n are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pos1 | input | POS_W | Signed position of carriage 1 |
| pos2 | input | POS_W | Signed position of carriage 2 |
| rx_avail_n | input | 1 | Low when the FIFO holds a byte from the host (asynchronous) |
| tx_room_n | input | 1 | Low when the FIFO can accept a byte (asynchronous) |
| bus_din | input | BUS_W | Data bus value read from the FIFO |
| bus_dout | output | BUS_W | Data bus value driven to the FIFO |
| bus_oe | output | 1 | Output enable for bus_dout; the bus is released when low |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| running | output | 1 | High while a sampling run is active |
| overrun | output | 1 | Sticky flag for a skipped tick |

## Verification
The main function is tried with several inputs:
- No command at all, which shows that a read waits on the status flag.
- An unknown command byte, which separates "ignored" from "started".
- Both valid commands, whose measured record spacing tells the short period from the long one.
- A run in which the transmit side is held full across several ticks, which separates a skipped tick from a queued one and shows the overrun flag being set and then cleared.

The position inputs move to new values in the middle of every record. Values with the sign bit set are included. This shows whether a record is a true snapshot and whether the byte order is correct.

// File: rtl/slc_pkg.sv
package slc_pkg;

  localparam logic [7:0] CMD_FAST = 8'h01;
  localparam logic [7:0] CMD_SLOW = 8'h02;

  typedef enum logic [2:0] {
    CT_IDLE,
    CT_CMD_WAIT,
    CT_WAIT_TICK,
    CT_LOAD,
    CT_SEND
  } ctl_state_e;

  typedef enum logic [2:0] {
    BP_IDLE,
    BP_RD_WAIT,
    BP_RD_STRB,
    BP_WR_WAIT,
    BP_WR_SETUP,
    BP_WR_STRB,
    BP_WR_HOLD,
    BP_RECOV
  } bus_state_e;

endpackage

// File: rtl/slc_sync2.sv
module slc_sync2 #(
  parameter int         W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta[i] <= RST_VAL[i];
        q[i]    <= RST_VAL[i];
      end else begin
        meta[i] <= d[i];
        q[i]    <= meta[i];
      end
    end
  end

endmodule

// File: rtl/slc_tick_gen.sv
module slc_tick_gen #(
  parameter int TICKS_FAST = 60000,
  parameter int TICKS_SLOW = 120000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sel_slow,
  output logic tick
);

  localparam int MAXP = (TICKS_SLOW > TICKS_FAST) ? TICKS_SLOW : TICKS_FAST;
  localparam int CW   = $clog2(MAXP + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    lim = sel_slow ? CW'(TICKS_SLOW - 1) : CW'(TICKS_FAST - 1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R4

endmodule

// File: rtl/slc_bus_port.sv
module slc_bus_port
  import slc_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int STROBE_CLKS = 4,
  parameter int RECOV_CLKS  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_go,
  input  logic             wr_go,
  input  logic [BUS_W-1:0] wr_byte,
  input  logic             rx_avail_s,
  input  logic             tx_room_s,
  input  logic [BUS_W-1:0] bus_din,
  output logic             rd_n,
  output logic             wr_n,
  output logic             bus_oe,
  output logic [BUS_W-1:0] bus_dout,
  output logic             rd_done,
  output logic [BUS_W-1:0] rd_byte,
  output logic             wr_done
);

  localparam int MAXC = (STROBE_CLKS > RECOV_CLKS) ? STROBE_CLKS : RECOV_CLKS;
  localparam int CW   = $clog2(MAXC + 1);

  bus_state_e    st;
  logic [CW-1:0] cnt;
  logic          pend_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= BP_IDLE;
      cnt      <= '0;
      pend_rd  <= 1'b0;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      bus_oe   <= 1'b0;
      bus_dout <= '0;
      rd_done  <= 1'b0;
      rd_byte  <= '0;
      wr_done  <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      wr_done <= 1'b0;
      case (st)
        BP_IDLE: begin
          if (rd_go) begin
            st <= BP_RD_WAIT;
          end else if (wr_go) begin
            bus_dout <= wr_byte;
            st       <= BP_WR_WAIT;
          end
        end
        BP_RD_WAIT: begin
          if (!rx_avail_s) begin
            rd_n <= 1'b0;
            cnt  <= '0;
            st   <= BP_RD_STRB;
          end
        end
        BP_RD_STRB: begin
          if (cnt == CW'(STROBE_CLKS - 1)) begin
            rd_byte <= bus_din;
            rd_n    <= 1'b1;
            cnt     <= '0;
            pend_rd <= 1'b1;
            st      <= BP_RECOV;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        BP_WR_WAIT: begin
          if (!tx_room_s) begin
            bus_oe <= 1'b1;
            st     <= BP_WR_SETUP;
          end
        end
        BP_WR_SETUP: begin
          wr_n <= 1'b0;
          cnt  <= '0;
          st   <= BP_WR_STRB;
        end
        BP_WR_STRB: begin
          if (cnt == CW'(STROBE_CLKS - 1)) begin
            wr_n <= 1'b1;
            st   <= BP_WR_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        BP_WR_HOLD: begin
          bus_oe  <= 1'b0;
          pend_rd <= 1'b0;
          cnt     <= '0;
          st      <= BP_RECOV;
        end
        BP_RECOV: begin
          if (cnt == CW'(RECOV_CLKS - 1)) begin
            st <= BP_IDLE;
            if (pend_rd) rd_done <= 1'b1;
            else         wr_done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= BP_IDLE;
      endcase
    end
  end

  AST_WR_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> bus_oe); // R7
  AST_WR_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !wr_n |=> (wr_n || $stable(bus_dout))); // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n)); // R10
  AST_RD_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n) |=> !rd_n); // R2

endmodule

// File: rtl/sample_link_ctrl.sv
module sample_link_ctrl
  import slc_pkg::*;
#(
  parameter int POS_W       = 16,
  parameter int BUS_W       = 8,
  parameter int TICKS_FAST  = 60000,
  parameter int TICKS_SLOW  = 120000,
  parameter int NUM_SAMPLES = 600,
  parameter int STROBE_CLKS = 4,
  parameter int RECOV_CLKS  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] pos1,
  input  logic [POS_W-1:0] pos2,
  input  logic             rx_avail_n,
  input  logic             tx_room_n,
  input  logic [BUS_W-1:0] bus_din,
  output logic [BUS_W-1:0] bus_dout,
  output logic             bus_oe,
  output logic             rd_n,
  output logic             wr_n,
  output logic             running,
  output logic             overrun
);

  localparam int REC_W     = 2 * POS_W;
  localparam int REC_BYTES = REC_W / BUS_W;
  localparam int IW        = (REC_BYTES > 1) ? $clog2(REC_BYTES) : 1;
  localparam int SCW       = $clog2(NUM_SAMPLES + 1);

  ctl_state_e       st;
  logic [REC_W-1:0] shreg;
  logic [IW-1:0]    bidx;
  logic [SCW-1:0]   scnt;
  logic             sel_slow;
  logic [1:0]       stat_s;
  logic             tick;
  logic             rd_go;
  logic             wr_go;
  logic             rd_done;
  logic             wr_done;
  logic [BUS_W-1:0] rd_byte;
  logic             cmd_ok;

  slc_sync2 #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({rx_avail_n, tx_room_n}),
    .q   (stat_s)
  );

  slc_tick_gen #(.TICKS_FAST(TICKS_FAST), .TICKS_SLOW(TICKS_SLOW)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .en       (running),
    .sel_slow (sel_slow),
    .tick     (tick)
  );

  slc_bus_port #(
    .BUS_W       (BUS_W),
    .STROBE_CLKS (STROBE_CLKS),
    .RECOV_CLKS  (RECOV_CLKS)
  ) u_port (
    .clk        (clk),
    .rst        (rst),
    .rd_go      (rd_go),
    .wr_go      (wr_go),
    .wr_byte    (shreg[BUS_W-1:0]),
    .rx_avail_s (stat_s[1]),
    .tx_room_s  (stat_s[0]),
    .bus_din    (bus_din),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .bus_oe     (bus_oe),
    .bus_dout   (bus_dout),
    .rd_done    (rd_done),
    .rd_byte    (rd_byte),
    .wr_done    (wr_done)
  );

  always_comb begin
    rd_go  = (st == CT_IDLE);
    wr_go  = (st == CT_LOAD);
    cmd_ok = (rd_byte == CMD_FAST) || (rd_byte == CMD_SLOW);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= CT_IDLE;
      shreg    <= '0;
      bidx     <= '0;
      scnt     <= '0;
      sel_slow <= 1'b0;
      running  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (running && tick && (st != CT_WAIT_TICK)) overrun <= 1'b1;
      case (st)
        CT_IDLE: st <= CT_CMD_WAIT;
        CT_CMD_WAIT: begin
          if (rd_done) begin
            if (cmd_ok) begin
              sel_slow <= (rd_byte == CMD_SLOW);
              running  <= 1'b1;
              overrun  <= 1'b0;
              scnt     <= '0;
              st       <= CT_WAIT_TICK;
            end else begin
              st <= CT_IDLE;
            end
          end
        end
        CT_WAIT_TICK: begin
          if (tick) begin
            shreg <= {pos2, pos1};
            bidx  <= '0;
            st    <= CT_LOAD;
          end
        end
        CT_LOAD: st <= CT_SEND;
        CT_SEND: begin
          if (wr_done) begin
            shreg <= shreg >> BUS_W;
            if (bidx == IW'(REC_BYTES - 1)) begin
              scnt <= scnt + 1'b1;
              if (scnt == SCW'(NUM_SAMPLES - 1)) begin
                running <= 1'b0;
                st      <= CT_IDLE;
              end else begin
                st <= CT_WAIT_TICK;
              end
            end else begin
              bidx <= bidx + 1'b1;
              st   <= CT_LOAD;
            end
          end
        end
        default: st <= CT_IDLE;
      endcase
    end
  end

  AST_SAMPLE_BOUND: assert property (@(posedge clk) disable iff (rst)
    running |-> (scnt < SCW'(NUM_SAMPLES))); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overrun && !(st == CT_CMD_WAIT && rd_done)) |=> overrun); // R9
  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (rst)
    (st == CT_SEND && !wr_done) |=> $stable(shreg)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !running |-> wr_n); // R8

endmodule

// File: tb/sample_link_ctrl_test.sv
module sample_link_ctrl_test;

  localparam int FAST = 100;
  localparam int SLOW = 200;
  localparam int NS   = 3;
  localparam int STRB = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [15:0] pos1, pos2;
  logic       rx_avail_n, tx_room_n;
  logic [7:0] bus_din, bus_dout;
  logic       bus_oe, rd_n, wr_n, running, overrun;

  int checks = 0, fails = 0;
  int cmd_req = 0, cmd_ack = 0;
  logic [7:0] cmd_byte = 8'h00;
  logic stall = 1'b0;
  bit finished = 0;

  int cyc = 0, nbytes = 0, rec_total = 0;
  int rd_len = 0, rd_last = 0, rd_falls = 0;
  int wr_len = 0, wr_min = 1000, wr_max = 0;
  int oe_err = 0, both_err = 0;
  logic prev_rd = 1'b1, prev_wr = 1'b1;
  logic [7:0] bytes_q [0:63];
  int rec_time [0:15];

  always #2 clk = ~clk;

  function automatic logic [15:0] f1(int k);
    return 16'(-1000 + 257 * k);
  endfunction
  function automatic logic [15:0] f2(int k);
    return 16'(20000 - 4099 * k);
  endfunction

  assign pos1       = f1(rec_total);
  assign pos2       = f2(rec_total);
  assign rx_avail_n = (cmd_req == cmd_ack);
  assign tx_room_n  = stall;

  sample_link_ctrl #(
    .TICKS_FAST(FAST), .TICKS_SLOW(SLOW), .NUM_SAMPLES(NS), .STROBE_CLKS(STRB)
  ) uut (
    .clk(clk), .rst(rst), .pos1(pos1), .pos2(pos2),
    .rx_avail_n(rx_avail_n), .tx_room_n(tx_room_n), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .rd_n(rd_n), .wr_n(wr_n),
    .running(running), .overrun(overrun)
  );

  // FIFO device model and bus monitor, evaluated away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst) begin
      if (!rd_n) begin rd_len = rd_len + 1; bus_din = cmd_byte; end
      if (!rd_n && prev_rd) rd_falls = rd_falls + 1;
      if (rd_n && !prev_rd) begin rd_last = rd_len; rd_len = 0; cmd_ack = cmd_ack + 1; end
      if (!wr_n) begin
        wr_len = wr_len + 1;
        if (!bus_oe) oe_err = oe_err + 1;
      end
      if (!wr_n && prev_wr && (nbytes % 4 == 0) && rec_total < 16) begin
        rec_time[rec_total] = cyc;
        rec_total = rec_total + 1;
      end
      if (wr_n && !prev_wr) begin
        if (nbytes < 64) bytes_q[nbytes] = bus_dout;
        nbytes = nbytes + 1;
        if (wr_len < wr_min) wr_min = wr_len;
        if (wr_len > wr_max) wr_max = wr_len;
        wr_len = 0;
      end
      if (!rd_n && !wr_n) both_err = both_err + 1;
    end else begin
      bus_din = 8'h00;
    end
    prev_rd = rd_n;
    prev_wr = wr_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk);
    cmd_byte = b;
    cmd_req  = cmd_req + 1;
  endtask

  task automatic wait_run_edge(input logic lvl);
    while (running !== lvl) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rd_n === 1'b1, "R1 rd_n", rd_n, 1);
    chk(wr_n === 1'b1, "R1 wr_n", wr_n, 1);
    chk(bus_oe === 1'b0, "R1 bus_oe", bus_oe, 0);
    chk(running === 1'b0, "R1 running", running, 0);
    chk(overrun === 1'b0, "R1 overrun", overrun, 0);
  endtask

  task automatic t_no_cmd;
    int f0 = rd_falls;
    repeat (60) @(negedge clk);
    chk(rd_falls == f0 && rd_n === 1'b1, "R2 read waits", rd_falls - f0, 0);
    chk(bus_oe === 1'b0, "R7 bus released while idle", bus_oe, 0);
  endtask

  task automatic t_bad_cmd;
    int b0 = nbytes;
    int a0 = cmd_ack;
    send_cmd(8'h07);
    while (cmd_ack == a0) @(negedge clk);
    chk(rd_last == STRB, "R2 read strobe width", rd_last, STRB);
    repeat (3 * FAST) @(negedge clk);
    chk(running === 1'b0, "R3 unknown command ignored", running, 0);
    chk(nbytes == b0, "R3 no write on unknown command", nbytes - b0, 0);
  endtask

  task automatic check_records(input int b0, input int r0, input string tag);
    int bad = 0;
    for (int r = 0; r < NS; r++) begin
      logic [15:0] e1 = f1(r0 + r);
      logic [15:0] e2 = f2(r0 + r);
      if (bytes_q[b0 + 4*r]     !== e1[7:0])  bad++;
      if (bytes_q[b0 + 4*r + 1] !== e1[15:8]) bad++;
      if (bytes_q[b0 + 4*r + 2] !== e2[7:0])  bad++;
      if (bytes_q[b0 + 4*r + 3] !== e2[15:8]) bad++;
    end
    chk(bad == 0, {tag, " R5 R6 record contents"}, bad, 0);
  endtask

  task automatic t_run(input logic [7:0] cmd, input int period, input string tag);
    int b0 = nbytes;
    int r0 = rec_total;
    send_cmd(cmd);
    wait_run_edge(1'b1);
    chk(overrun === 1'b0, {tag, " R9 overrun clear at run start"}, overrun, 0);
    wait_run_edge(1'b0);
    chk(nbytes - b0 == 4 * NS, {tag, " R8 byte count"}, nbytes - b0, 4 * NS);
    check_records(b0, r0, tag);
    for (int i = 0; i + 1 < NS; i++)
      chk(rec_time[r0+i+1] - rec_time[r0+i] == period, {tag, " R4 record spacing"},
          rec_time[r0+i+1] - rec_time[r0+i], period);
    chk(wr_min == STRB && wr_max == STRB, {tag, " R7 write strobe width"}, wr_max, STRB);
    chk(oe_err == 0, {tag, " R7 oe during strobe"}, oe_err, 0);
    chk(both_err == 0, {tag, " R10 strobes exclusive"}, both_err, 0);
    repeat (3 * SLOW) @(negedge clk);
    chk(nbytes - b0 == 4 * NS, {tag, " R8 no bytes after run"}, nbytes - b0, 4 * NS);
    chk(bus_oe === 1'b0, {tag, " R7 bus released after run"}, bus_oe, 0);
  endtask

  task automatic t_overrun;
    int b0 = nbytes;
    int r0 = rec_total;
    stall = 1'b1;
    send_cmd(8'h01);
    wait_run_edge(1'b1);
    repeat (FAST * 5 / 2) @(negedge clk);
    chk(nbytes == b0 && wr_n === 1'b1, "R7 write waits while full", nbytes - b0, 0);
    chk(overrun === 1'b1, "R9 overrun set", overrun, 1);
    stall = 1'b0;
    wait_run_edge(1'b0);
    chk(nbytes - b0 == 4 * NS, "R9 skipped tick adds no record", nbytes - b0, 4 * NS);
    check_records(b0, r0, "overrun");
    chk(overrun === 1'b1, "R9 overrun sticky", overrun, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset;
    rst = 1'b0;
    t_reset;
    t_no_cmd;
    t_bad_cmd;
    t_run(8'h01, FAST, "fast R3");
    t_overrun;
    t_run(8'h02, SLOW, "slow R3");
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule